// File: doc/BRIEF.md
# Descriptor Execution and Report Engine

This block is the sequencing core of one DMA channel. It pulls four-word descriptors from a descriptor queue, one word per cycle. It then models the transfer time of each descriptor. The byte length counts down by a fixed number of bytes on each transfer beat, and beats come at a programmable rate. Memory traffic is not performed. When a descriptor finishes, the engine pushes a four-word report into a report queue. The report carries a snapshot of a free-running 64-bit timestamp, the byte length, and the descriptor's 8-bit tag. If the descriptor asked for a notification, the engine also raises a one-cycle done pulse.

The engine has a sticky repeat mode. Once any descriptor with the repeat flag has been accepted, the engine never idles again until reset. After every report, it either loads the next waiting descriptor or runs the current one again. The 64-bit timestamp counter lives inside the block and advances on an external tick strobe, for example a 24 MHz enable. A channel enable freezes all progress while it is low.

Top module: `dxe_engine`

## Requirements
- R1: A descriptor is four 32-bit words taken in this order: address low, address high, byte length, flags. In the flags word, bits [7:0] are the tag, bit 16 requests a done pulse and bit 17 requests repeat. A word is taken on a cycle with desc_valid and desc_ready both high. desc_ready is high only while chan_en is high and the engine waits for a descriptor (never while a report is pending).
- R2: Bytes per beat equal the word bytes times the frame words. word_width codes: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. frame_size codes: 0 = 1 word, 1 = 2 words, 2 or 3 = 4 words. A descriptor completes on beat number ceil(length / bytes per beat), and on the first beat when the length is 0.
- R3: While running and enabled, a beat occurs every rate_div+1 cycles. The first report word is pushed B*(rate_div+1)+1 cycles after the last descriptor word is taken, where B is the beat count from R2 and no stall or disable intervenes.
- R4: A report is four words pushed on consecutive rpt_push cycles, in this order: timestamp low, timestamp high, the descriptor's byte length, a flags word. The flags word has bits [7:0] equal to the descriptor tag and all other bits 0.
- R5: The reported timestamp is the counter value on the clock edge of the completing beat. The counter has 63 bits that start at 0 after reset and add 1 on each edge with ts_tick high, and its bit 63 always reads 1.
- R6: rpt_push is never high while rpt_full is high. A blocked report is held unchanged and is delivered complete once rpt_full falls.
- R7: done_pulse is high for exactly one cycle, the cycle after the fourth report word is pushed, and only when the descriptor's notify bit (flags bit 16) was set.
- R8: After a descriptor with the repeat bit is accepted, a sticky repeat state holds until rst_n falls. In that state, at the end of each report the engine takes the next descriptor if desc_valid is high, otherwise it runs the current descriptor again with its full length.
- R9: While chan_en is low, no descriptor word is taken, no beat occurs and no report word is pushed. Work resumes where it stopped when chan_en rises.
- R10: After reset, rpt_push and done_pulse are low and desc_ready follows chan_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_en | input | 1 | Channel enable; all progress halts while low |
| word_width | input | 2 | Bus word width code |
| frame_size | input | 2 | Frame size code |
| rate_div | input | DIV_W | Beat period minus one, in cycles |
| ts_tick | input | 1 | Timestamp counter advance strobe |
| desc_valid | input | 1 | Descriptor queue has a word |
| desc_word | input | WORD_W | Descriptor word at the queue head |
| desc_ready | output | 1 | Engine takes the head word this cycle |
| rpt_full | input | 1 | Report queue cannot accept a word |
| rpt_push | output | 1 | Report word written this cycle |
| rpt_word | output | WORD_W | Report word data |
| done_pulse | output | 1 | Notify event for a finished descriptor |

## Verification
The hardest situation to reach is the sticky repeat state after its hand-off to a new descriptor. Here the first descriptor must re-run several times, then yield exactly once to a queued descriptor that itself carries no repeat bit, and that descriptor must then re-run. The stimulus sends a repeating descriptor, lets it loop, and queues a plain one. It then records the tag sequence of every report and checks that the sequence is a run of the first tag followed only by the second. A reset then ends the loop, and a final plain descriptor must yield exactly one report. Stalls are reached by toggling rpt_full on every cycle in the middle of a report, and by dropping chan_en partway through a long countdown. The second case has an exactly predicted delivery latency.

// File: rtl/dxe_pkg.sv
package dxe_pkg;

    // Engine sequencing states
    typedef enum logic [1:0] {
        ST_FETCH  = 2'd0,
        ST_RUN    = 2'd1,
        ST_REPORT = 2'd2
    } dxe_state_e;

    localparam int TAG_W    = 8;
    localparam int NOTIFY_B = 16;
    localparam int REPEAT_B = 17;
    localparam int STEP_W   = 5;

    // Bytes per beat from the word width and frame size codes
    function automatic logic [STEP_W-1:0] beat_bytes(input logic [1:0] wsel,
                                                     input logic [1:0] fsel);
        logic [STEP_W-1:0] wb;
        logic [1:0]        fs;
        case (wsel)
            2'd0:    wb = 5'd1;
            2'd1:    wb = 5'd2;
            default: wb = 5'd4;
        endcase
        fs = (fsel >= 2'd2) ? 2'd2 : fsel;
        return wb << fs;
    endfunction

endpackage

// File: rtl/dxe_ts_counter.sv
// Free-running timestamp counter.
// Holds TS_W-1 counting bits that advance on each tick strobe; the top
// bit of the presented value is tied high. Assumes tick is synchronous.
module dxe_ts_counter #(
    parameter int TS_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    output logic [TS_W-1:0] ts
);

    logic [TS_W-2:0] cnt_q;

    // Advance the count on every tick strobe
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= cnt_q + 1'b1;
    end

    assign ts = {1'b1, cnt_q};

endmodule

// File: rtl/dxe_beat_gen.sv
// Transfer beat pacing.
// Emits one beat every div+1 cycles while run is high; the phase is
// cleared by restart and frozen while run is low.
module dxe_beat_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             beat
);

    logic [DIV_W-1:0] phase_q;

    assign beat = run && (phase_q == div);

    // Step the phase counter, wrapping on each beat
    always_ff @(posedge clk) begin
        if (!rst_n)       phase_q <= '0;
        else if (restart) phase_q <= '0;
        else if (run)     phase_q <= beat ? '0 : phase_q + 1'b1;
    end

endmodule

// File: rtl/dxe_core.sv
// Descriptor sequencer.
// Collects a four-word descriptor, counts its length down on each beat,
// snapshots the timestamp on the completing beat and emits a four-word
// report, then fetches again or re-runs under sticky repeat. Assumes the
// beat input is only high while the run output is high.
module dxe_core
    import dxe_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                chan_en,
    input  logic [1:0]          word_width,
    input  logic [1:0]          frame_size,
    input  logic [2*WORD_W-1:0] ts_now,
    input  logic                beat,
    input  logic                desc_valid,
    input  logic [WORD_W-1:0]   desc_word,
    output logic                desc_ready,
    input  logic                rpt_full,
    output logic                rpt_push,
    output logic [WORD_W-1:0]   rpt_word,
    output logic                done_pulse,
    output logic                run,
    output logic                restart,
    output logic                rpt_busy
);

    localparam int TS_W = 2 * WORD_W;

    dxe_state_e          state_q;
    logic [1:0]          widx_q;
    logic [WORD_W-1:0]   len_q;
    logic [WORD_W-1:0]   rem_q;
    logic [TAG_W-1:0]    tag_q;
    logic                notify_q;
    logic                sticky_q;
    logic [TS_W-1:0]     stamp_q;
    logic                done_q;

    logic [WORD_W-1:0]   step;
    logic                desc_fire;
    logic                last_fetch;
    logic                last_push;
    logic                rerun;
    logic                finish;

    assign step       = {{(WORD_W-STEP_W){1'b0}}, beat_bytes(word_width, frame_size)};
    assign desc_ready = chan_en && (state_q == ST_FETCH);
    assign desc_fire  = desc_ready && desc_valid;
    assign last_fetch = desc_fire && (widx_q == 2'd3);
    assign rpt_push   = chan_en && (state_q == ST_REPORT) && !rpt_full;
    assign last_push  = rpt_push && (widx_q == 2'd3);
    assign rerun      = last_push && sticky_q && !desc_valid;
    assign restart    = last_fetch || rerun;
    assign run        = chan_en && (state_q == ST_RUN);
    assign finish     = beat && (rem_q <= step);
    assign rpt_busy   = (state_q == ST_REPORT);
    assign done_pulse = done_q;

    // Sequence through fetch, countdown and report phases
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
            widx_q  <= 2'd0;
        end else begin
            case (state_q)
                ST_FETCH: if (desc_fire) begin
                    widx_q <= widx_q + 2'd1;
                    if (widx_q == 2'd3) state_q <= ST_RUN;
                end
                ST_RUN: if (finish) state_q <= ST_REPORT;
                ST_REPORT: if (rpt_push) begin
                    widx_q <= widx_q + 2'd1;
                    if (widx_q == 2'd3) state_q <= rerun ? ST_RUN : ST_FETCH;
                end
                default: state_q <= ST_FETCH;
            endcase
        end
    end

    // Capture descriptor fields and the sticky repeat state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q    <= '0;
            tag_q    <= '0;
            notify_q <= 1'b0;
            sticky_q <= 1'b0;
        end else if (desc_fire) begin
            if (widx_q == 2'd2) len_q <= desc_word;
            if (widx_q == 2'd3) begin
                tag_q    <= desc_word[TAG_W-1:0];
                notify_q <= desc_word[NOTIFY_B];
                sticky_q <= sticky_q | desc_word[REPEAT_B];
            end
        end
    end

    // Count the remaining length down per beat, reload on each start
    always_ff @(posedge clk) begin
        if (!rst_n)                 rem_q <= '0;
        else if (last_fetch)        rem_q <= len_q;
        else if (rerun)             rem_q <= len_q;
        else if (beat && !finish)   rem_q <= rem_q - step;
    end

    // Snapshot the timestamp on the completing beat
    always_ff @(posedge clk) begin
        if (!rst_n)      stamp_q <= '0;
        else if (finish) stamp_q <= ts_now;
    end

    // Raise the notify event after the last report word
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= last_push && notify_q;
    end

    // Select the report word for the current index
    always_comb begin
        case (widx_q)
            2'd0:    rpt_word = stamp_q[WORD_W-1:0];
            2'd1:    rpt_word = stamp_q[TS_W-1:WORD_W];
            2'd2:    rpt_word = len_q;
            default: rpt_word = {{(WORD_W-TAG_W){1'b0}}, tag_q};
        endcase
    end

endmodule

// File: rtl/dxe_engine.sv
// Descriptor execution and report engine, top level.
// Joins the timestamp counter, beat pacing and descriptor sequencer for
// one channel. Assumes both queue interfaces present their head/full
// state combinationally in the same cycle.
module dxe_engine #(
    parameter int WORD_W = 32,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_en,
    input  logic [1:0]        word_width,
    input  logic [1:0]        frame_size,
    input  logic [DIV_W-1:0]  rate_div,
    input  logic              ts_tick,
    input  logic              desc_valid,
    input  logic [WORD_W-1:0] desc_word,
    output logic              desc_ready,
    input  logic              rpt_full,
    output logic              rpt_push,
    output logic [WORD_W-1:0] rpt_word,
    output logic              done_pulse
);

    localparam int TS_W = 2 * WORD_W;

    logic [TS_W-1:0] ts_now;
    logic            beat;
    logic            run;
    logic            restart;
    logic            rpt_busy;

    dxe_ts_counter #(.TS_W(TS_W)) ts_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (ts_tick),
        .ts    (ts_now)
    );

    dxe_beat_gen #(.DIV_W(DIV_W)) beat_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .run     (run),
        .div     (rate_div),
        .beat    (beat)
    );

    dxe_core #(.WORD_W(WORD_W)) core_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_en    (chan_en),
        .word_width (word_width),
        .frame_size (frame_size),
        .ts_now     (ts_now),
        .beat       (beat),
        .desc_valid (desc_valid),
        .desc_word  (desc_word),
        .desc_ready (desc_ready),
        .rpt_full   (rpt_full),
        .rpt_push   (rpt_push),
        .rpt_word   (rpt_word),
        .done_pulse (done_pulse),
        .run        (run),
        .restart    (restart),
        .rpt_busy   (rpt_busy)
    );

endmodule

// File: rtl/dxe_engine_chk.sv
// Protocol checker for dxe_engine, attached by bind.
// Observes the queue handshakes, the done event and the timestamp.
module dxe_engine_chk #(
    parameter int WORD_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                chan_en,
    input logic                ts_tick,
    input logic                desc_ready,
    input logic                rpt_full,
    input logic                rpt_push,
    input logic [WORD_W-1:0]   rpt_word,
    input logic                done_pulse,
    input logic                rpt_busy,
    input logic [2*WORD_W-1:0] ts_now
);

    localparam int TS_W = 2 * WORD_W;

    // R6: no write into a full report queue
    a_r6_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_full |-> !rpt_push);

    // R6: a blocked report word is held
    a_r6_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_busy && !rpt_push) |=> $stable(rpt_word));

    // R9: nothing moves while the channel is disabled
    a_r9_frozen_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |-> (!desc_ready && !rpt_push));

    // R1: no descriptor intake while a report is pending
    a_r1_no_fetch_in_report: assert property (@(posedge clk) disable iff (!rst_n)
        desc_ready |-> !rpt_busy);

    // R7: done lasts one cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

    // R7: done follows a report push
    a_r7_done_after_push: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> $past(rpt_push));

    // R5: timestamp top bit reads one
    a_r5_ts_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
        ts_now[TS_W-1]);

    // R5: timestamp advances by one per tick
    a_r5_ts_step: assert property (@(posedge clk) disable iff (!rst_n)
        ts_tick |=> (ts_now[TS_W-2:0] == $past(ts_now[TS_W-2:0]) + 1'b1));

endmodule

bind dxe_engine dxe_engine_chk #(.WORD_W(WORD_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .chan_en    (chan_en),
    .ts_tick    (ts_tick),
    .desc_ready (desc_ready),
    .rpt_full   (rpt_full),
    .rpt_push   (rpt_push),
    .rpt_word   (rpt_word),
    .done_pulse (done_pulse),
    .rpt_busy   (rpt_busy),
    .ts_now     (ts_now)
);

// File: tb/dxe_engine_tb_top.sv
// Scoreboard bench for dxe_engine: tasks queue descriptor words and the
// expected reports; a monitor on the falling edge drives the descriptor
// queue head and compares every report as it is pushed.
module dxe_engine_tb_top;

    typedef struct {
        logic [7:0]  tag;
        logic [31:0] len;
        int unsigned ts_min;
        bit          exact;
        bit          notify;
        int          lat;
    } exp_t;

    localparam int WATCHDOG = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chan_en = 1'b1;
    logic [1:0]  word_width = 2'd2;
    logic [1:0]  frame_size = 2'd0;
    logic [7:0]  rate_div = 8'd0;
    logic        ts_tick = 1'b0;
    logic        desc_valid = 1'b0;
    logic [31:0] desc_word = '0;
    logic        desc_ready;
    logic        rpt_full = 1'b0;
    logic        rpt_push;
    logic [31:0] rpt_word;
    logic        done_pulse;

    int          n_checks = 0;
    int          n_errors = 0;
    int          cyc = 0;
    int unsigned tick_count = 0;
    logic [31:0] dq[$];
    exp_t        eq[$];
    bit          fire_pending = 0;
    int          wcnt = 0;
    int          last_w3 = 0;
    logic [31:0] rw[4];
    int          rcnt = 0;
    int          first_push_cyc = 0;
    bit          done_due = 0;
    bit          done_exp = 0;
    int          pushes = 0;
    bit          collect = 0;
    logic [7:0]  got[$];

    always #10 clk = ~clk;

    dxe_engine #(.WORD_W(32), .DIV_W(8)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_en    (chan_en),
        .word_width (word_width),
        .frame_size (frame_size),
        .rate_div   (rate_div),
        .ts_tick    (ts_tick),
        .desc_valid (desc_valid),
        .desc_word  (desc_word),
        .desc_ready (desc_ready),
        .rpt_full   (rpt_full),
        .rpt_push   (rpt_push),
        .rpt_word   (rpt_word),
        .done_pulse (done_pulse)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    // Compare one complete report with the scoreboard head
    task automatic score_report();
        exp_t e;
        if (collect) begin
            got.push_back(rw[3][7:0]);
            return;
        end
        if (eq.size() == 0) begin
            check(0, "R8", "unexpected report tag", rw[3], 0);
            return;
        end
        e = eq.pop_front();
        check(rw[3] == {24'd0, e.tag}, "R4", "flags word", rw[3], {24'd0, e.tag});
        check(rw[2] == e.len, "R4", "aux length word", rw[2], e.len);
        check(rw[1] == 32'h8000_0000, "R5", "timestamp high", rw[1], 32'h8000_0000);
        if (e.exact)
            check(rw[0] == e.ts_min, "R5", "timestamp low", rw[0], e.ts_min);
        else
            check(rw[0] >= e.ts_min && rw[0] <= tick_count, "R5", "timestamp window",
                  rw[0], e.ts_min);
        if (e.lat >= 0)
            check(first_push_cyc - last_w3 == e.lat, "R3", "report latency",
                  first_push_cyc - last_w3, e.lat);
        done_due = 1;
        done_exp = e.notify;
    endtask

    // Monitor: drive the descriptor queue head, observe handshakes
    always @(negedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            check(0, "R3", "watchdog expired", cyc, WATCHDOG);
            finish_sim();
        end
        if (fire_pending) begin
            void'(dq.pop_front());
            fire_pending = 0;
        end
        desc_valid = (dq.size() > 0);
        desc_word  = desc_valid ? dq[0] : 32'd0;
        #1;
        if (!rst_n) begin
            tick_count = 0;
            wcnt = 0;
            rcnt = 0;
            done_due = 0;
        end else begin
            if (ts_tick) tick_count++;
            if (done_due) begin
                check(done_pulse == done_exp, "R7", "done pulse", done_pulse, done_exp);
                done_due = 0;
            end else if (done_pulse && !collect) begin
                check(0, "R7", "stray done pulse", 1, 0);
            end
            if (desc_valid && desc_ready) begin
                fire_pending = 1;
                if (wcnt == 3) last_w3 = cyc;
                wcnt = (wcnt + 1) % 4;
            end
            if (rpt_push) begin
                pushes++;
                rw[rcnt] = rpt_word;
                if (rcnt == 0) first_push_cyc = cyc;
                if (rcnt == 3) score_report();
                rcnt = (rcnt + 1) % 4;
            end
        end
    end

    // Queue a descriptor's words, optionally with its expected report
    task automatic send(input logic [7:0] tag, input logic [31:0] len, input bit notify,
                        input bit rpt, input int lat, input bit exact, input bit expect_it);
        exp_t e;
        dq.push_back(32'h0000_1000 + {24'd0, tag});
        dq.push_back(32'd0);
        dq.push_back(len);
        dq.push_back({14'd0, rpt, notify, 8'd0, tag});
        if (expect_it) begin
            e.tag = tag; e.len = len; e.ts_min = tick_count; e.exact = exact;
            e.notify = notify; e.lat = lat;
            eq.push_back(e);
        end
    endtask

    task automatic cfg(input logic [1:0] w, input logic [1:0] f, input logic [7:0] d);
        @(negedge clk);
        word_width = w; frame_size = f; rate_div = d;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (eq.size() == 0 && rcnt == 0 && dq.size() == 0) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        dq.delete();
        eq.delete();
        fire_pending = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        int p0;
        int n50;
        int n51;
        bit order_ok;
        do_reset();
        @(negedge clk); #2;
        // R10: reset state
        check(rpt_push == 1'b0, "R10", "rpt_push after reset", rpt_push, 0);
        check(done_pulse == 1'b0, "R10", "done after reset", done_pulse, 0);
        check(desc_ready == 1'b1, "R10", "desc_ready follows enable", desc_ready, 1);

        // Advance the timestamp to a known value, then hold it
        @(negedge clk); ts_tick = 1'b1;
        repeat (37) @(negedge clk);
        ts_tick = 1'b0;
        @(negedge clk);

        // R1 R2 R3 R4 R5 R7: 32-bit words, 16 bytes, beat every cycle
        cfg(2'd2, 2'd0, 8'd0);
        send(8'h01, 32'd16, 1, 0, 4*1+1, 1, 1);
        wait_idle();
        // R2 R3: 1-byte words, 4-word frames, 10 bytes, period 3
        cfg(2'd0, 2'd2, 8'd2);
        send(8'h02, 32'd10, 0, 0, 3*3+1, 1, 1);
        wait_idle();
        // R2 R3: 2-byte words, 7 bytes, period 2
        cfg(2'd1, 2'd0, 8'd1);
        send(8'h03, 32'd7, 1, 0, 4*2+1, 1, 1);
        wait_idle();
        // R2: zero length finishes on the first beat
        cfg(2'd2, 2'd1, 8'd0);
        send(8'h04, 32'd0, 1, 0, 1*1+1, 1, 1);
        wait_idle();
        // R5: counter running through the transfer
        cfg(2'd2, 2'd2, 8'd3);
        @(negedge clk); ts_tick = 1'b1;
        send(8'h05, 32'd64, 0, 0, 4*4+1, 0, 1);
        wait_idle();
        ts_tick = 1'b0;
        // R1 R3: three descriptors queued back to back
        cfg(2'd1, 2'd1, 8'd1);
        @(negedge clk);
        send(8'h06, 32'd8, 1, 0, 2*2+1, 1, 1);
        send(8'h07, 32'd12, 0, 0, 3*2+1, 1, 1);
        send(8'hA8, 32'd4, 1, 0, 1*2+1, 1, 1);
        wait_idle();

        // R6: full report queue blocks, then flickers mid-report
        cfg(2'd2, 2'd0, 8'd0);
        rpt_full = 1'b1;
        send(8'h09, 32'd8, 1, 0, -1, 1, 1);
        p0 = pushes;
        repeat (30) @(negedge clk);
        check(pushes == p0, "R6", "pushes while full", pushes - p0, 0);
        check(eq.size() == 1, "R6", "report still pending", eq.size(), 1);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            rpt_full = ~rpt_full;
        end
        rpt_full = 1'b0;
        wait_idle();

        // R9: disabled channel takes no descriptor words
        @(negedge clk);
        chan_en = 1'b0;
        p0 = pushes;
        send(8'h0A, 32'd4, 0, 0, -1, 1, 1);
        repeat (40) @(negedge clk);
        check(dq.size() == 4, "R9", "words taken while disabled", 4 - dq.size(), 0);
        check(pushes == p0, "R9", "pushes while disabled", pushes - p0, 0);
        chan_en = 1'b1;
        wait_idle();
        // R9: disable for 20 cycles inside a 40-beat countdown
        cfg(2'd0, 2'd0, 8'd0);
        send(8'h0B, 32'd40, 1, 0, 40*1+1+20, 1, 1);
        repeat (15) @(negedge clk);
        chan_en = 1'b0;
        repeat (20) @(negedge clk);
        chan_en = 1'b1;
        wait_idle();

        // R8: sticky repeat, hand-off to a plain descriptor
        cfg(2'd2, 2'd0, 8'd0);
        collect = 1;
        got.delete();
        send(8'h50, 32'd4, 0, 1, -1, 1, 0);
        repeat (40) @(negedge clk);
        send(8'h51, 32'd8, 0, 0, -1, 1, 0);
        repeat (60) @(negedge clk);
        do_reset();
        n50 = 0; n51 = 0; order_ok = 1;
        foreach (got[i]) begin
            if (got[i] == 8'h50 && n51 == 0) n50++;
            else if (got[i] == 8'h51) n51++;
            else order_ok = 0;
        end
        check(n50 >= 2, "R8", "re-runs of repeat descriptor", n50, 2);
        check(n51 >= 2, "R8", "re-runs of later descriptor", n51, 2);
        check(order_ok, "R8", "report tag order", 0, 1);
        collect = 0;

        // R8: reset clears the sticky state; one report only
        @(negedge clk);
        send(8'h60, 32'd4, 1, 0, 1*1+1, 1, 1);
        wait_idle();
        p0 = pushes;
        repeat (30) @(negedge clk);
        check(pushes == p0, "R8", "pushes after single run", pushes - p0, 0);
        check(eq.size() == 0, "R4", "reports outstanding", eq.size(), 0);
        finish_sim();
    end

endmodule